// File: doc/BRIEF.md
# Bidirectional 8-bit Timer with Compare and Overflow Flags

This block is an 8-bit timer/counter driven by a host register port. A free-running prescaler turns the system clock into timer ticks at one of five rates, or produces none at all. On each tick the counter does one of three things: it clears to zero, counts up by one, or counts down by one. Which one it does depends on the selected counting mode and on the current direction.

An equality comparator runs all the time and compares the count with a compare register. Two sticky flags are kept: one for a compare event and one for an overflow event. Each flag drives an interrupt request, which is gated by its own enable and by a global enable input. Each flag is cleared either by an acknowledge pulse or by the host writing a one to its bit. The counter also reports when it sits at its maximum or at zero.

The host writes a register by pulsing `host_wr` with an address and a data byte. It reads a register by presenting an address, and the data appears on `host_rdata` after the next clock edge.

Top module: `updown_timer8`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the count, compare value, control byte and both flags are zero, and so are both interrupt requests. `host_rdata` is 0, `cnt_bottom` is 1 and `cnt_top` is 0.
- R2: When the clock-select field is 0, 6 or 7, the count holds its value. The host can still write and read the count in this state.
- R3: Clock-select values 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 system clocks. The ticks come from a free-running 10-bit prescaler, so any window of N×rate consecutive clocks holds exactly N ticks.
- R4: A host write to the count takes effect even in a cycle that has a tick. The written value is loaded, and the clear, increment or decrement of that cycle is discarded.
- R5: In mode 0, each tick increments the count, and 0xFF wraps to 0x00. The tick that wraps sets the overflow flag.
- R6: In mode 1, the count rises to 0xFF, then falls to 0x00, then rises again. The overflow flag is set on the tick that brings the count down to 0x00, and not on the tick that leaves 0x00.
- R7: In modes 2 and 3, every tick clears the count to zero.
- R8: `cnt_top` is 1 exactly while the count is 0xFF, and `cnt_bottom` is 1 exactly while the count is 0x00.
- R9: The compare flag is set by the first tick whose pre-edge count equals the compare value. It is not set in the cycle where the equality first appears.
- R10: `cmp_irq` is the compare flag ANDed with control bit 5 and `irq_global_en`. `ovf_irq` is the overflow flag ANDed with control bit 6 and `irq_global_en`.
- R11: A flag is cleared when the host writes a one to its bit, or when its acknowledge input (`cmp_ack`, `ovf_ack`) is high at a clock edge. Writing a zero to a flag bit leaves that flag unchanged.
- R12: If a flag is set and cleared in the same cycle, the set wins.
- R13: Register map. Address 0 is the count and address 1 is the compare value. Address 2 is the control byte: bits [2:0] clock select, bits [4:3] mode, bit 5 compare interrupt enable, bit 6 overflow interrupt enable. Address 3 holds the flags: bit 0 compare, bit 1 overflow. `host_rdata` shows the register at `host_addr` as it stood before the latest clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for one cycle |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq_global_en | input | 1 | Global interrupt enable |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| cnt_top | output | 1 | Count is at its maximum |
| cnt_bottom | output | 1 | Count is zero |

## Verification
Two pairs of events can fall on the same clock edge. The first is a host write to the count and a tick. The bench provokes it by writing the count while the timer runs at the full rate. It then stops the timer one edge later, so the value read back shows whether the load replaced the increment. The second pair is a flag being set and cleared at once. The bench places a write-one to the compare flag exactly on the tick where the flag is set, and it expects the flag to read back as 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_DUAL  = 2'd1,
    MODE_CLR_A = 2'd2,
    MODE_CLR_B = 2'd3
  } mode_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam int FLAG_CMP = 0;
  localparam int FLAG_OVF = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 10,
  parameter int CS_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CS_W-1:0] clk_sel,
  output logic            tick
);
  localparam int TAP_8    = 3;
  localparam int TAP_64   = 6;
  localparam int TAP_256  = 8;
  localparam int TAP_1024 = 10;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    case (clk_sel)
      CS_W'(1): tick = 1'b1;
      CS_W'(2): tick = &pre_q[TAP_8-1:0];
      CS_W'(3): tick = &pre_q[TAP_64-1:0];
      CS_W'(4): tick = &pre_q[TAP_256-1:0];
      CS_W'(5): tick = &pre_q[TAP_1024-1:0];
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  tmr_pkg::mode_e    mode,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_evt,
  output logic              at_top,
  output logic              at_bot
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    ovf_evt = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      case (mode)
        MODE_WRAP: begin
          cnt_d   = cnt_q + ONE;
          ovf_evt = (cnt_q == MAXV);
        end
        MODE_DUAL: begin
          if (up_q) begin
            if (cnt_q == MAXV) begin
              cnt_d = cnt_q - ONE;
              up_d  = 1'b0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d = ONE;
              up_d  = 1'b1;
            end else begin
              cnt_d   = cnt_q - ONE;
              ovf_evt = (cnt_q == ONE);
            end
          end
        end
        default: cnt_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt    = cnt_q;
  assign at_top = (cnt_q == MAXV);
  assign at_bot = (cnt_q == '0);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/updown_timer8.sv
module updown_timer8 #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 10,
  parameter int CS_W   = 3,
  parameter int MODE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [1:0]       host_addr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rdata,
  input  logic             irq_global_en,
  input  logic             cmp_ack,
  input  logic             ovf_ack,
  output logic             cmp_irq,
  output logic             ovf_irq,
  output logic             cnt_top,
  output logic             cnt_bottom
);
  import tmr_pkg::*;

  localparam int MODE_LSB = CS_W;
  localparam int CIE_BIT  = CS_W + MODE_W;
  localparam int OIE_BIT  = CIE_BIT + 1;
  localparam int CTRL_W   = OIE_BIT + 1;

  logic [CS_W-1:0]      cs_q;
  mode_e                mode_q;
  logic                 cie_q, oie_q;
  logic [CNT_W-1:0]     cmp_q;
  logic [CNT_W-1:0]     cnt;
  logic                 tick, ovf_evt, cmp_match, cnt_wr;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q, flag_ack;
  logic                 wdata_unused;

  assign cnt_wr       = host_wr && (host_addr == ADDR_CNT);
  assign wdata_unused = ^host_wdata;

  tmr_prescaler #(.PRE_W(PRE_W), .CS_W(CS_W)) u_pre (
    .clk(clk), .rst(rst), .clk_sel(cs_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_q),
    .load(cnt_wr), .load_val(host_wdata), .cnt(cnt),
    .ovf_evt(ovf_evt), .at_top(cnt_top), .at_bot(cnt_bottom)
  );

  assign cmp_match = (cnt == cmp_q);

  assign flag_set[FLAG_CMP] = tick && cmp_match;
  assign flag_set[FLAG_OVF] = ovf_evt;
  assign flag_ack[FLAG_CMP] = cmp_ack;
  assign flag_ack[FLAG_OVF] = ovf_ack;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flag_clr[i] = flag_ack[i] ||
                         (host_wr && (host_addr == ADDR_FLAG) && host_wdata[i]);
    tmr_flag u_flag (
      .clk(clk), .rst(rst), .set(flag_set[i]), .clr(flag_clr[i]), .flag(flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= '0;
      mode_q <= MODE_WRAP;
      cie_q  <= 1'b0;
      oie_q  <= 1'b0;
      cmp_q  <= '0;
    end else if (host_wr) begin
      if (host_addr == ADDR_CMP) cmp_q <= host_wdata;
      if (host_addr == ADDR_CTRL) begin
        cs_q   <= host_wdata[CS_W-1:0];
        mode_q <= mode_e'(host_wdata[MODE_LSB +: MODE_W]);
        cie_q  <= host_wdata[CIE_BIT];
        oie_q  <= host_wdata[OIE_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_addr)
        ADDR_CNT:  host_rdata <= cnt;
        ADDR_CMP:  host_rdata <= cmp_q;
        ADDR_CTRL: host_rdata <= CNT_W'({oie_q, cie_q, mode_q, cs_q});
        default:   host_rdata <= CNT_W'(flag_q);
      endcase
    end
  end

  assign cmp_irq = flag_q[FLAG_CMP] && cie_q && irq_global_en;
  assign ovf_irq = flag_q[FLAG_OVF] && oie_q && irq_global_en;

  logic [CTRL_W-1:0] ctrl_view_unused;
  assign ctrl_view_unused = {oie_q, cie_q, mode_q, cs_q};
endmodule

// File: rtl/updown_timer8_chk.sv
module updown_timer8_chk #(
  parameter int CNT_W = 8,
  parameter int CS_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic [1:0]       host_addr,
  input logic [CNT_W-1:0] host_wdata,
  input logic             irq_global_en,
  input logic             cmp_ack,
  input logic             cmp_irq,
  input logic             cnt_bottom,
  input logic [CNT_W-1:0] cnt,
  input logic [CS_W-1:0]  cs_q,
  input logic [1:0]       mode_bits,
  input logic             tick,
  input logic             cmp_match,
  input logic             cmp_flag,
  input logic             ovf_flag
);
  logic cnt_wr;
  assign cnt_wr = host_wr && (host_addr == 2'd0);

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((cs_q == '0) && !cnt_wr) |=> $stable(cnt)); // R2

  AST_HOST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(host_wdata))); // R4

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
    (tick && (mode_bits == 2'd0) && (cnt == '1) && !cnt_wr) |=> (ovf_flag && cnt_bottom)); // R5

  AST_CMP_SET_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick && cmp_match) |=> cmp_flag); // R9

  AST_CMP_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> $past(tick && cmp_match)); // R9

  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> (irq_global_en && cmp_flag)); // R10

  AST_WRITE_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && host_wr && (host_addr == 2'd3) && !host_wdata[0] && !cmp_ack) |=> cmp_flag); // R11
endmodule

bind updown_timer8 updown_timer8_chk #(.CNT_W(CNT_W), .CS_W(CS_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .irq_global_en(irq_global_en), .cmp_ack(cmp_ack),
  .cmp_irq(cmp_irq), .cnt_bottom(cnt_bottom), .cnt(cnt), .cs_q(cs_q),
  .mode_bits(mode_q), .tick(tick), .cmp_match(cmp_match),
  .cmp_flag(flag_q[0]), .ovf_flag(flag_q[1])
);

// File: tb/updown_timer8_tb.sv
module updown_timer8_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       irq_global_en = 1'b0;
  logic       cmp_ack = 1'b0;
  logic       ovf_ack = 1'b0;
  logic       cmp_irq, ovf_irq, cnt_top, cnt_bottom;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_timer8 u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_global_en(irq_global_en), .cmp_ack(cmp_ack), .ovf_ack(ovf_ack),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .cnt_top(cnt_top), .cnt_bottom(cnt_bottom)
  );

  function automatic logic [7:0] ctl(input int cs, input int mode, input bit cie, input bit oie);
    return {1'b0, oie, cie, 2'(mode), 3'(cs)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  // run the timer for 'edges' clock edges, then stop it with clock select 0
  task automatic run(input int cs, input int mode, input bit cie, input bit oie, input int edges);
    wr(2'd2, ctl(cs, mode, cie, oie));
    repeat (edges - 1) @(negedge clk);
    wr(2'd2, ctl(0, mode, cie, oie));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 bottom", cnt_bottom, 1);
    chk("R1 top", cnt_top, 0);
    chk("R1 irqs", {cmp_irq, ovf_irq}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    wr(2'd0, 8'h55);
    repeat (20) @(negedge clk);
    rd(2'd0, v);
    chk("R2 hold cs0", v, 8'h55);
    run(7, 0, 0, 0, 50);
    rd(2'd0, v);
    chk("R2 hold cs7", v, 8'h55);
    run(6, 0, 0, 0, 40);
    rd(2'd0, v);
    chk("R2 hold cs6", v, 8'h55);
    wr(2'd1, 8'hA7);
    rd(2'd1, v);
    chk("R13 compare readback", v, 8'hA7);
    wr(2'd2, ctl(0, 2, 1, 1));
    rd(2'd2, v);
    chk("R13 control readback", v, 8'h70);
  endtask

  task automatic t_rates();
    logic [7:0] v;
    wr(2'd0, 8'h10);
    run(1, 0, 0, 0, 5);
    rd(2'd0, v);
    chk("R3 cs1", v, 8'h15);
    wr(2'd0, 8'h00);
    run(2, 0, 0, 0, 80);
    rd(2'd0, v);
    chk("R3 cs2", v, 10);
    wr(2'd0, 8'h00);
    run(3, 0, 0, 0, 128);
    rd(2'd0, v);
    chk("R3 cs3", v, 2);
    wr(2'd0, 8'h00);
    run(4, 0, 0, 0, 512);
    rd(2'd0, v);
    chk("R3 cs4", v, 2);
    wr(2'd0, 8'h00);
    run(5, 0, 0, 0, 1024);
    rd(2'd0, v);
    chk("R3 cs5", v, 1);
  endtask

  task automatic t_override();
    logic [7:0] v;
    wr(2'd0, 8'h10);
    wr(2'd2, ctl(1, 0, 0, 0));
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h80);
    wr(2'd2, ctl(0, 0, 0, 0));
    rd(2'd0, v);
    chk("R4 write beats tick", v, 8'h81);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    irq_global_en = 1'b1;
    wr(2'd3, 8'h03);
    wr(2'd0, 8'hFE);
    wr(2'd2, ctl(1, 0, 0, 1));
    chk("R8 top below max", cnt_top, 0);
    @(negedge clk);
    chk("R8 top at max", cnt_top, 1);
    chk("R5 no ovf before wrap", ovf_irq, 0);
    @(negedge clk);
    chk("R8 bottom after wrap", cnt_bottom, 1);
    chk("R5 ovf on wrap", ovf_irq, 1);
    wr(2'd2, ctl(0, 0, 0, 1));
    chk("R8 bottom left", cnt_bottom, 0);
    rd(2'd0, v);
    chk("R5 count after wrap", v, 8'h01);
    ovf_ack = 1'b1;
    @(negedge clk);
    ovf_ack = 1'b0;
    chk("R11 ovf ack clears", ovf_irq, 0);
  endtask

  task automatic t_dual();
    logic [7:0] v;
    wr(2'd3, 8'h03);
    wr(2'd0, 8'hFE);
    run(1, 1, 0, 0, 3);
    rd(2'd0, v);
    chk("R6 turn at top", v, 8'hFD);
    rd(2'd3, v);
    chk("R6 no ovf at top", v, 0);
    wr(2'd0, 8'h02);
    run(1, 1, 0, 0, 2);
    rd(2'd0, v);
    chk("R6 down to zero", v, 0);
    rd(2'd3, v);
    chk("R6 ovf at bottom", v, 2);
    wr(2'd3, 8'h02);
    run(1, 1, 0, 0, 1);
    rd(2'd0, v);
    chk("R6 turn at bottom", v, 1);
    rd(2'd3, v);
    chk("R6 no ovf leaving bottom", v, 0);
  endtask

  task automatic t_clear_modes();
    logic [7:0] v;
    wr(2'd0, 8'h40);
    run(1, 2, 0, 0, 3);
    rd(2'd0, v);
    chk("R7 mode2 clears", v, 0);
    wr(2'd0, 8'h41);
    run(1, 3, 0, 0, 1);
    rd(2'd0, v);
    chk("R7 mode3 clears", v, 0);
  endtask

  task automatic t_compare();
    logic [7:0] v;
    irq_global_en = 1'b1;
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h1E);
    wr(2'd2, ctl(1, 0, 1, 0));
    @(negedge clk);
    @(negedge clk);
    chk("R9 no flag on equality cycle", cmp_irq, 0);
    @(negedge clk);
    chk("R9 flag one tick later", cmp_irq, 1);
    wr(2'd2, ctl(0, 0, 1, 0));
    irq_global_en = 1'b0;
    #1;
    chk("R10 global gate", cmp_irq, 0);
    irq_global_en = 1'b1;
    #1;
    chk("R10 global on", cmp_irq, 1);
    @(negedge clk);
    wr(2'd2, ctl(0, 0, 0, 0));
    chk("R10 local enable gate", cmp_irq, 0);
    wr(2'd2, ctl(0, 0, 1, 0));
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    chk("R11 write zero keeps", v, 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v);
    chk("R11 write one clears", v, 0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h1F);
    wr(2'd2, ctl(1, 0, 1, 0));
    @(negedge clk);
    wr(2'd3, 8'h01);
    wr(2'd2, ctl(0, 0, 1, 0));
    rd(2'd3, v);
    chk("R12 set beats clear", v, 1);
    cmp_ack = 1'b1;
    @(negedge clk);
    cmp_ack = 1'b0;
    rd(2'd3, v);
    chk("R11 cmp ack clears", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_rates();
    t_override();
    t_wrap();
    t_dual();
    t_clear_modes();
    t_compare();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule